// File: doc/BRIEF.md
# Memory strobe timing generator

This block drives the two active-low control strobes of one external memory access: a write strobe and a read (output-enable) strobe. A start pulse latches a packed 32-bit timing word, the access type and a multiplexed-mode flag, and then starts a cycle counter at zero. Each strobe is driven low while the counter sits between its programmed assert count and its programmed release count. Either strobe can be moved half a clock period later. In a multiplexed address/address/data read, the read strobe also gets a second window for the first address phase.

Cycle numbering at the ports works as follows. The rising edge that samples an accepted start is edge 0. The strobe and done levels after rising edge k (k ≥ 1) reflect count k−1. Only the write strobe moves on a write, and only the read strobe moves on a read. Once the count reaches the end count, the access closes with a one-cycle done pulse, and both strobes stay high until the next accepted start.

Top module: `strobe_timer`

## Requirements
- R1: While reset is high, and on the first edge after it, both strobes are high and done is low.
- R2: On a write, the write strobe is low after edge k exactly when WA ≤ k−1 < WR. WA is the 4-bit assert count in bits 19:16, and WR is the 5-bit release count in bits 28:24.
- R3: On a read, the read strobe is low after edge k when RA ≤ k−1 < RR. RA is the 4-bit assert count in bits 3:0, and RR is the 5-bit release count in bits 12:8.
- R4: On a read with the multiplexed flag set, the read strobe is also low when PA ≤ k−1 < PR. PA is the 3-bit assert count in bits 6:4, and PR is the 3-bit release count in bits 15:13. Without the flag, this window has no effect.
- R5: Bit 23 (write strobe) or bit 7 (read strobe), when set, delays that strobe by half a period. In that case, shortly after rising edge k the strobe still shows count k−2 (high for k=1), and after the falling edge it shows count k−1.
- R6: A window whose release count is less than or equal to its assert count never drives its strobe low.
- R7: The write strobe stays high on a read, and the read strobe stays high on a write.
- R8: The end count is the largest of WR, RR and, when the multiplexed flag is set, PR. Done is high only after edge end+1, for one cycle. Both strobes are high afterwards.
- R9: A start pulse during an access is ignored. A change of the timing word during an access does not alter that access.
- R10: Bits 31:29 and 22:20 have no effect on either strobe or on done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start of access, accepted only when idle |
| is_write_i | input | 1 | 1 = write access, 0 = read access |
| mux_mode_i | input | 1 | Multiplexed address/address/data access |
| cfg_i | input | 32 | Packed timing word |
| we_n_o | output | 1 | Active-low write strobe |
| oe_n_o | output | 1 | Active-low read strobe |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
A wrong counter value or a wrong captured timing field shows at the ports within one cycle. The affected strobe edge moves by whole cycles, or the done pulse appears early or late. A broken half-period path shows only in the first half of each cycle, so the bench samples both before and after the falling edge. A lost busy state shows either as an early done or as a second access started by the ignored mid-access pulse, and the next sample after that pulse detects it.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int PH_W  = 3;
  localparam int CNT_W = OFF_W;
  localparam int CFG_W = 32;

  typedef struct packed {
    logic [2:0]       rsv_hi;
    logic [OFF_W-1:0] wr_off;
    logic             wr_half;
    logic [2:0]       rsv_mid;
    logic [ON_W-1:0]  wr_on;
    logic [PH_W-1:0]  ph_off;
    logic [OFF_W-1:0] rd_off;
    logic             rd_half;
    logic [PH_W-1:0]  ph_on;
    logic [ON_W-1:0]  rd_on;
  } timing_cfg_t;

  function automatic logic [CNT_W-1:0] end_count(timing_cfg_t c, logic mux);
    logic [CNT_W-1:0] m;
    m = (c.wr_off > c.rd_off) ? c.wr_off : c.rd_off;
    if (mux && CNT_W'(c.ph_off) > m) m = CNT_W'(c.ph_off);
    return m;
  endfunction
endpackage

// File: rtl/strobe_timer_ctrl.sv
module strobe_timer_ctrl
  import strobe_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 is_write_i,
  input  logic                 mux_mode_i,
  input  logic [CFG_W-1:0]     cfg_i,
  output logic                 busy_o,
  output logic [CNT_W-1:0]     cnt_o,
  output timing_cfg_t          cfg_o,
  output logic                 wr_o,
  output logic                 mux_o,
  output logic                 done_o
);
  logic [CNT_W-1:0] last;

  assign last = end_count(cfg_o, mux_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      cfg_o  <= '0;
      wr_o   <= 1'b0;
      mux_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= busy_o && (cnt_o == last);
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          cnt_o  <= '0;
          cfg_o  <= timing_cfg_t'(cfg_i);
          wr_o   <= is_write_i;
          mux_o  <= mux_mode_i;
        end
      end else if (cnt_o == last) begin
        busy_o <= 1'b0;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strobe_timer_lane.sv
module strobe_timer_lane
  import strobe_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic             alt_en_i,
  input  logic [CNT_W-1:0] alt_on_i,
  input  logic [CNT_W-1:0] alt_off_i,
  input  logic             half_i,
  output logic             strobe_n_o
);
  logic main_win, alt_win;
  logic rise_q, fall_q;

  assign main_win = (cnt_i >= on_i) && (cnt_i < off_i);
  assign alt_win  = alt_en_i && (cnt_i >= alt_on_i) && (cnt_i < alt_off_i);

  always_ff @(posedge clk) begin
    if (rst) rise_q <= 1'b1;
    else     rise_q <= !(en_i && (main_win || alt_win));
  end

  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b1;
    else     fall_q <= rise_q;
  end

  assign strobe_n_o = half_i ? fall_q : rise_q;
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
  import strobe_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic             mux_mode_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             done_o
);
  logic             busy;
  logic [CNT_W-1:0] cnt_q;
  timing_cfg_t      cfg_q;
  logic             wr_q, mux_q;
  logic             unused_rsv;

  assign unused_rsv = ^{cfg_q.rsv_hi, cfg_q.rsv_mid};

  strobe_timer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
    .mux_mode_i(mux_mode_i), .cfg_i(cfg_i), .busy_o(busy), .cnt_o(cnt_q),
    .cfg_o(cfg_q), .wr_o(wr_q), .mux_o(mux_q), .done_o(done_o)
  );

  strobe_timer_lane u_we (
    .clk(clk), .rst(rst), .en_i(busy && wr_q), .cnt_i(cnt_q),
    .on_i(CNT_W'(cfg_q.wr_on)), .off_i(cfg_q.wr_off),
    .alt_en_i(1'b0), .alt_on_i('0), .alt_off_i('0),
    .half_i(cfg_q.wr_half), .strobe_n_o(we_n_o)
  );

  strobe_timer_lane u_oe (
    .clk(clk), .rst(rst), .en_i(busy && !wr_q), .cnt_i(cnt_q),
    .on_i(CNT_W'(cfg_q.rd_on)), .off_i(cfg_q.rd_off),
    .alt_en_i(mux_q), .alt_on_i(CNT_W'(cfg_q.ph_on)),
    .alt_off_i(CNT_W'(cfg_q.ph_off)),
    .half_i(cfg_q.rd_half), .strobe_n_o(oe_n_o)
  );
endmodule

// File: rtl/strobe_timer_chk.sv
module strobe_timer_chk
  import strobe_timer_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy,
  input logic [CNT_W-1:0] cnt_q,
  input timing_cfg_t      cfg_q,
  input logic             we_n_o,
  input logic             oe_n_o,
  input logic             done_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (we_n_o && oe_n_o && !done_o));

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!we_n_o && !oe_n_o));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy);

  a_r2_start_zero: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i) |=> (busy && cnt_q == '0));

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |=> $stable(cfg_q));
endmodule

bind strobe_timer strobe_timer_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy), .cnt_q(cnt_q),
  .cfg_q(cfg_q), .we_n_o(we_n_o), .oe_n_o(oe_n_o), .done_o(done_o)
);

// File: tb/strobe_timer_tb_top.sv
module strobe_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        is_write_i = 1'b0;
  logic        mux_mode_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic        we_n_o, oe_n_o, done_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  strobe_timer dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
    .mux_mode_i(mux_mode_i), .cfg_i(cfg_i), .we_n_o(we_n_o),
    .oe_n_o(oe_n_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string req, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t: got %0d expected %0d", req, tag, $time, act, exp);
    end
  endtask

  function automatic bit we_low(logic [31:0] c, bit wr, int n);
    if (n < 0 || !wr) return 0;
    return (n >= int'(c[19:16])) && (n < int'(c[28:24]));
  endfunction

  function automatic bit oe_low(logic [31:0] c, bit wr, bit mux, int n);
    bit m, p;
    if (n < 0 || wr) return 0;
    m = (n >= int'(c[3:0])) && (n < int'(c[12:8]));
    p = mux && (n >= int'(c[6:4])) && (n < int'(c[15:13]));
    return m || p;
  endfunction

  function automatic int end_of(logic [31:0] c, bit mux);
    int m;
    m = (c[28:24] > c[12:8]) ? int'(c[28:24]) : int'(c[12:8]);
    if (mux && int'(c[15:13]) > m) m = int'(c[15:13]);
    return m;
  endfunction

  task automatic run_access(logic [31:0] c, bit wr, bit mux, string tag);
    int    last;
    bit    we_e, oe_e;
    string wl, ol;
    last = end_of(c, mux);
    wl = wr ? "R2" : "R7";
    ol = wr ? "R7" : (mux ? "R4" : "R3");
    cfg_i = c; is_write_i = wr; mux_mode_i = mux; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    cfg_i = $urandom;          // R9: mid-access word change
    is_write_i = !wr;
    mux_mode_i = !mux;
    for (int j = 1; j <= last + 1; j++) begin
      @(posedge clk); #2;
      if (j == 3) start_i = 1'b0;
      we_e = c[23] ? !we_low(c, wr, j - 2) : !we_low(c, wr, j - 1);
      oe_e = c[7] ? !oe_low(c, wr, mux, j - 2) : !oe_low(c, wr, mux, j - 1);
      chk(we_n_o == we_e, c[23] ? "R5" : wl, tag, we_n_o, we_e);
      chk(oe_n_o == oe_e, c[7] ? "R5" : ol, tag, oe_n_o, oe_e);
      #5;
      we_e = !we_low(c, wr, j - 1);
      oe_e = !oe_low(c, wr, mux, j - 1);
      chk(we_n_o == we_e, wl, tag, we_n_o, we_e);
      chk(oe_n_o == oe_e, ol, tag, oe_n_o, oe_e);
      chk(done_o == (j == last + 1), "R8", tag, done_o, j == last + 1);
      if (j == 2 && last >= 2) start_i = 1'b1;  // R9: ignored restart
    end
    start_i = 1'b0;
    @(posedge clk); #7;
    chk(we_n_o == 1'b1, "R8", tag, we_n_o, 1);
    chk(oe_n_o == 1'b1, "R8", tag, oe_n_o, 1);
    chk(done_o == 1'b0, "R8", tag, done_o, 0);
  endtask

  function automatic logic [31:0] pack(int woff, bit wh, int won, int poff,
                                       int roff, bit rh, int pon, int ron);
    return {3'b0, woff[4:0], wh, 3'b0, won[3:0], poff[2:0], roff[4:0], rh,
            pon[2:0], ron[3:0]};
  endfunction

  initial begin
    logic [31:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk(we_n_o && oe_n_o && !done_o, "R1", "reset", {we_n_o, oe_n_o, done_o}, 3'b110);
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #7;
    chk(we_n_o && oe_n_o && !done_o, "R1", "after reset", {we_n_o, oe_n_o, done_o}, 3'b110);
    run_access('0, 1'b1, 1'b0, "all zero");
    run_access(pack(6, 0, 2, 0, 0, 0, 0, 0), 1'b1, 1'b0, "R2 write");
    run_access(pack(0, 0, 0, 0, 9, 0, 0, 3), 1'b0, 1'b0, "R3 read");
    run_access(pack(0, 0, 0, 3, 10, 0, 1, 5), 1'b0, 1'b1, "R4 mux read");
    run_access(pack(0, 0, 0, 7, 4, 0, 2, 1), 1'b0, 1'b0, "R4 no mux");
    run_access(pack(8, 1, 3, 0, 0, 0, 0, 0), 1'b1, 1'b0, "R5 we half");
    run_access(pack(0, 0, 0, 0, 6, 1, 0, 2), 1'b0, 1'b0, "R5 oe half");
    run_access(pack(4, 0, 4, 0, 2, 0, 0, 9), 1'b1, 1'b0, "R6 empty we");
    run_access(pack(0, 0, 0, 2, 3, 0, 5, 7), 1'b0, 1'b1, "R6 empty oe");
    run_access(pack(31, 0, 15, 0, 31, 0, 0, 0), 1'b0, 1'b0, "R7 read max");
    run_access(pack(12, 0, 1, 0, 20, 0, 0, 1), 1'b1, 1'b0, "R9 restart");
    c = pack(9, 0, 2, 5, 11, 0, 1, 4) | 32'hE070_0000;
    run_access(c, 1'b1, 1'b1, "R10 reserved wr");
    run_access(c, 1'b0, 1'b1, "R10 reserved rd");
    for (int i = 0; i < 150; i++) begin
      c = $urandom;
      run_access(c, 1'($urandom), 1'($urandom), "random");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule